// File: doc/BRIEF.md
# Mailbox Flash Command Controller

This block puts a register-mapped mailbox in front of a small internal flash-like memory. A host fills a sixteen-word data window through a simple write port and then writes a command word. The command word carries an opcode, a word count, a word address, a header-select flag and a request bit. The controller then runs the operation and posts a status word. When it finishes, it clears the request bit, and the host polls that bit to learn that the command is done.

The memory has three regions. Two equal banks hold an active image and an inactive image, and a smaller header region sits beside them. Reads take data from the active bank. Writes go to the inactive bank. A successful update-authenticate command swaps the two banks. The authentication verdict comes from an input pin. A power-cycle command raises a one-cycle request pulse and does nothing else.

The engine is a four-state machine:
- **IDLE**: on an accepted command with the request bit set, it latches the fields and takes *start* to CHECK.
- **CHECK**: it decodes the opcode and tests the bounds. An in-range read or write takes *go* to MOVE. Every other case takes *settle* to FINISH with its result code.
- **MOVE**: it transfers one word per cycle and takes *last* to FINISH after the final word.
- **FINISH**: it writes the status, clears the request bit and takes *retire* back to IDLE.

Top module: `fmb_ctrl`

## Requirements
- R1: Host register map (5-bit offsets):
  - offsets 1..16 are the data window, words 0..15;
  - offset 17 is the command register;
  - offset 18 is the read-only status register;
  - every other offset reads as zero;
  - while idle, data window writes read back unchanged.
- R2: Command word fields are opcode [31:28], count [27:24], word address [23:2], header select [1] and request [0]. A command starts only when the written word has bit 0 set.
- R3: The request bit reads 1 while a command runs and is cleared when the command finishes. At that point the status word has bit 29 set, the finished opcode in [7:4], the result code in [3:0] and all other bits zero.
- R4: Read (opcode 2) copies N words into data window words 0..N-1. N equals the count field, and a count of 0 means 16. The words come from the active bank, starting at the word address. Window words at N and above keep their values.
- R5: Write (opcode 0) copies count+1 window words to the inactive bank, starting at the word address. Reads of the active bank do not see the new data.
- R6: With header select set, reads and writes use the header region (HDR_WORDS words) instead of a bank.
- R7: If address plus word total exceeds the size of the target region, the command finishes with result code 2 and copies nothing. Ending exactly at the region end is allowed.
- R8: Update-authenticate (opcode 1) with auth_pass_i high swaps the active and inactive banks and reports code 0. With auth_pass_i low it reports code 1 and leaves the banks as they were.
- R9: Power-cycle (opcode 4) reports code 0 and raises pwr_cycle_o for exactly one cycle. No other command raises it.
- R10: Any other opcode reports result code 3 and touches neither memory nor the data window.
- R11: A command-register write made while the request bit is set is ignored. This includes the cycle in which the bit clears.
- R12: Data window writes made while the request bit is set are ignored.
- R13: After reset, all registers, all memory words and the bank selection are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_waddr | input | 5 | Host write offset |
| hst_wdata | input | 32 | Host write data |
| hst_raddr | input | 5 | Host read offset |
| hst_rdata | output | 32 | Host read data (combinational) |
| auth_pass_i | input | 1 | Authentication verdict, sampled in CHECK |
| pwr_cycle_o | output | 1 | One-cycle power-cycle request |

## Verification
Two pairs of actions can fall in the same cycle.

The first pair is a host command write and the *retire* edge that clears the request bit. The bench starts a sixteen-word write and then drives a power-cycle command on every cycle until it reads the request bit clear, so the last attempt is sampled on the very edge that finishes the command. The run is judged correct when:
- the status names the write opcode;
- the command register still holds the write opcode;
- no power-cycle pulse has appeared.

The second pair is a host data-window write and an engine write to the window during a read. A host window write is also sent while a short command is busy, and the bench checks that the window word keeps its old value.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
    localparam int WIN_WORDS = 16;
    localparam int HOST_AW   = 5;
    localparam logic [HOST_AW-1:0] OFF_WIN_LO = 5'd1;
    localparam logic [HOST_AW-1:0] OFF_WIN_HI = 5'd16;
    localparam logic [HOST_AW-1:0] OFF_CMD    = 5'd17;
    localparam logic [HOST_AW-1:0] OFF_STAT   = 5'd18;

    localparam logic [3:0] OP_WRITE = 4'd0;
    localparam logic [3:0] OP_AUTH  = 4'd1;
    localparam logic [3:0] OP_READ  = 4'd2;
    localparam logic [3:0] OP_PWR   = 4'd4;

    localparam logic [3:0] RC_OK     = 4'd0;
    localparam logic [3:0] RC_AUTH   = 4'd1;
    localparam logic [3:0] RC_ACCESS = 4'd2;
    localparam logic [3:0] RC_OPCODE = 4'd3;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  cnt;
        logic [21:0] addr;
        logic        hdr;
        logic        req;
    } fmb_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MOVE,
        ST_FINISH
    } fmb_state_e;
endpackage

// File: rtl/fmb_store.sv
module fmb_store
    import fmb_pkg::*;
#(
    parameter int BANK_WORDS = 32,
    parameter int HDR_WORDS  = 16,
    parameter int AW         = $clog2(BANK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          hdr_i,
    output logic [31:0]   rd_data_o,
    input  logic          wr_en_i,
    input  logic [31:0]   wr_data_i,
    input  logic          swap_i
);
    localparam int TOT = 2 * BANK_WORDS + HDR_WORDS;
    localparam int PW  = $clog2(TOT);

    logic [31:0] mem_q [TOT];
    logic        active_q;

    function automatic logic [PW-1:0] phys(input logic hdr, input logic bank,
                                           input logic [AW-1:0] a);
        if (hdr)
            return PW'(2 * BANK_WORDS) + PW'(a);
        else if (bank)
            return PW'(BANK_WORDS) + PW'(a);
        else
            return PW'(a);
    endfunction

    logic [PW-1:0] rd_idx, wr_idx;
    assign rd_idx    = phys(hdr_i, active_q, addr_i);
    assign wr_idx    = phys(hdr_i, ~active_q, addr_i);
    assign rd_data_o = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            for (int k = 0; k < TOT; k++) mem_q[k] <= '0;
        end else begin
            if (swap_i) active_q <= ~active_q;
            if (wr_en_i) mem_q[wr_idx] <= wr_data_i;
        end
    end

    // R8
    swap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> active_q != $past(active_q));
endmodule

// File: rtl/fmb_engine.sv
module fmb_engine
    import fmb_pkg::*;
#(
    parameter int BANK_WORDS = 32,
    parameter int HDR_WORDS  = 16,
    parameter int AW         = $clog2(BANK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [3:0]    op_i,
    input  logic [3:0]    cnt_i,
    input  logic [21:0]   addr_i,
    input  logic          hdr_i,
    input  logic          auth_pass_i,
    input  logic [31:0]   mem_rdata_i,
    input  logic [31:0]   win_rdata_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_hdr_o,
    output logic          mem_we_o,
    output logic [31:0]   mem_wdata_o,
    output logic [3:0]    win_idx_o,
    output logic          win_we_o,
    output logic [31:0]   win_wdata_o,
    output logic          swap_o,
    output logic          done_o,
    output logic          pwr_o,
    output logic [3:0]    op_o,
    output logic [3:0]    code_o
);
    fmb_state_e  state_q, state_d;
    logic [3:0]  op_q, code_q, idx_q;
    logic [4:0]  n_q, n_nxt;
    logic [21:0] base_q;
    logic        hdr_q;
    logic [22:0] limit, span_end;
    logic        is_xfer, over, last;

    assign n_nxt    = (op_i == OP_WRITE) ? ({1'b0, cnt_i} + 5'd1)
                    : ((cnt_i == 4'd0) ? 5'(WIN_WORDS) : {1'b0, cnt_i});
    assign limit    = hdr_q ? 23'(HDR_WORDS) : 23'(BANK_WORDS);
    assign span_end = {1'b0, base_q} + 23'(n_q);
    assign is_xfer  = (op_q == OP_READ) || (op_q == OP_WRITE);
    assign over     = span_end > limit;
    assign last     = ({1'b0, idx_q} + 5'd1) == n_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, go, settle, last, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = (is_xfer && !over) ? ST_MOVE : ST_FINISH;
            ST_MOVE:   if (last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            code_q <= '0;
            idx_q  <= '0;
            n_q    <= '0;
            base_q <= '0;
            hdr_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                op_q   <= op_i;
                n_q    <= n_nxt;
                base_q <= addr_i;
                hdr_q  <= hdr_i;
            end
            if (state_q == ST_CHECK) begin
                idx_q <= '0;
                case (op_q)
                    OP_READ, OP_WRITE: code_q <= over ? RC_ACCESS : RC_OK;
                    OP_AUTH:           code_q <= auth_pass_i ? RC_OK : RC_AUTH;
                    OP_PWR:            code_q <= RC_OK;
                    default:           code_q <= RC_OPCODE;
                endcase
            end
            if (state_q == ST_MOVE) idx_q <= idx_q + 4'd1;
        end
    end

    // outputs
    always_comb begin
        mem_we_o = 1'b0;
        win_we_o = 1'b0;
        swap_o   = 1'b0;
        done_o   = 1'b0;
        pwr_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CHECK:  swap_o = (op_q == OP_AUTH) && auth_pass_i;
            ST_MOVE: begin
                mem_we_o = (op_q == OP_WRITE);
                win_we_o = (op_q == OP_READ);
            end
            ST_FINISH: begin
                done_o = 1'b1;
                pwr_o  = (op_q == OP_PWR);
            end
            default: ;
        endcase
    end

    assign mem_addr_o  = base_q[AW-1:0] + AW'(idx_q);
    assign mem_hdr_o   = hdr_q;
    assign mem_wdata_o = win_rdata_i;
    assign win_wdata_o = mem_rdata_i;
    assign win_idx_o   = idx_q;
    assign op_o        = op_q;
    assign code_o      = code_q;

    // R7
    xfer_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MOVE |-> ({1'b0, base_q} + 23'(idx_q)) < limit);
    // R4
    move_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MOVE |-> {1'b0, idx_q} < n_q);
endmodule

// File: rtl/fmb_ctrl.sv
module fmb_ctrl
    import fmb_pkg::*;
#(
    parameter int BANK_WORDS = 32,
    parameter int HDR_WORDS  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_wr_en,
    input  logic [4:0]  hst_waddr,
    input  logic [31:0] hst_wdata,
    input  logic [4:0]  hst_raddr,
    output logic [31:0] hst_rdata,
    input  logic        auth_pass_i,
    output logic        pwr_cycle_o
);
    localparam int AW = $clog2(BANK_WORDS);

    logic [31:0] win_q [WIN_WORDS];
    logic [31:0] cmd_q, stat_q;
    fmb_cmd_t    wcmd;
    logic        busy, cmd_acc, win_hit;
    logic [4:0]  win_off;

    logic [AW-1:0] m_addr;
    logic          m_hdr, m_we, e_win_we, e_swap, e_done;
    logic [31:0]   m_rdata, m_wdata, e_win_wdata;
    logic [3:0]    e_win_idx, e_op, e_code;

    assign wcmd    = fmb_cmd_t'(hst_wdata);
    assign busy    = cmd_q[0];
    assign cmd_acc = hst_wr_en && (hst_waddr == OFF_CMD) && !busy;
    assign win_hit = hst_wr_en && (hst_waddr >= OFF_WIN_LO) && (hst_waddr <= OFF_WIN_HI) && !busy;
    assign win_off = hst_waddr - OFF_WIN_LO;

    fmb_engine #(.BANK_WORDS(BANK_WORDS), .HDR_WORDS(HDR_WORDS), .AW(AW)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(cmd_acc && wcmd.req),
        .op_i(wcmd.op), .cnt_i(wcmd.cnt), .addr_i(wcmd.addr), .hdr_i(wcmd.hdr),
        .auth_pass_i(auth_pass_i),
        .mem_rdata_i(m_rdata), .win_rdata_i(win_q[e_win_idx]),
        .mem_addr_o(m_addr), .mem_hdr_o(m_hdr), .mem_we_o(m_we), .mem_wdata_o(m_wdata),
        .win_idx_o(e_win_idx), .win_we_o(e_win_we), .win_wdata_o(e_win_wdata),
        .swap_o(e_swap), .done_o(e_done), .pwr_o(pwr_cycle_o),
        .op_o(e_op), .code_o(e_code)
    );

    fmb_store #(.BANK_WORDS(BANK_WORDS), .HDR_WORDS(HDR_WORDS), .AW(AW)) store_i (
        .clk(clk), .rst_n(rst_n),
        .addr_i(m_addr), .hdr_i(m_hdr), .rd_data_o(m_rdata),
        .wr_en_i(m_we), .wr_data_i(m_wdata), .swap_i(e_swap)
    );

    for (genvar g = 0; g < WIN_WORDS; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_q[g] <= '0;
            else if (e_win_we && e_win_idx == 4'(g))
                win_q[g] <= e_win_wdata;
            else if (win_hit && win_off[3:0] == 4'(g))
                win_q[g] <= hst_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
        end else begin
            if (cmd_acc)
                cmd_q <= hst_wdata;
            else if (e_done)
                cmd_q[0] <= 1'b0;
            if (e_done)
                stat_q <= {2'b00, 1'b1, 21'd0, e_op, e_code};
        end
    end

    always_comb begin
        hst_rdata = '0;
        if (hst_raddr >= OFF_WIN_LO && hst_raddr <= OFF_WIN_HI)
            hst_rdata = win_q[4'(hst_raddr - OFF_WIN_LO)];
        else if (hst_raddr == OFF_CMD)
            hst_rdata = cmd_q;
        else if (hst_raddr == OFF_STAT)
            hst_rdata = stat_q;
    end

    // R3
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_done |=> !cmd_q[0]);
    // R3
    resp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_done |=> stat_q[29] && stat_q[7:4] == $past(e_op));
    // R11
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_wr_en && hst_waddr == OFF_CMD) |=> cmd_q[31:1] == $past(cmd_q[31:1]));
    // R9
    pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle_o |=> !pwr_cycle_o);
    // R12
    busy_win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hst_wr_en && hst_waddr == OFF_WIN_LO && !(e_win_we && e_win_idx == 4'd0))
        |=> win_q[0] == $past(win_q[0]));
endmodule

// File: tb/fmb_ctrl_tb.sv
`timescale 1ns/1ps
module fmb_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en = 1'b0;
    logic [4:0]  hst_waddr = '0;
    logic [31:0] hst_wdata = '0;
    logic [4:0]  hst_raddr = '0;
    logic [31:0] hst_rdata;
    logic        auth_pass_i = 1'b0;
    logic        pwr_cycle_o;

    int total = 0;
    int bad = 0;
    int pcount = 0;

    always #5 clk = ~clk;

    fmb_ctrl dut_i (.*);

    always @(posedge clk) if (rst_n && pwr_cycle_o) pcount++;

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] cnt,
                                       input logic [21:0] a, input logic hdr);
        return {op, cnt, a, hdr, 1'b1};
    endfunction

    // {command, auth verdict, expected status}
    localparam logic [64:0] VEC [8] = '{
        {mk(4'd0, 4'd3, 22'd0,  1'b0), 1'b0, 32'h2000_0000},
        {mk(4'd1, 4'd0, 22'd0,  1'b0), 1'b1, 32'h2000_0010},
        {mk(4'd2, 4'd4, 22'd0,  1'b0), 1'b0, 32'h2000_0020},
        {mk(4'd0, 4'd3, 22'd30, 1'b0), 1'b0, 32'h2000_0002},
        {mk(4'd2, 4'd0, 22'd20, 1'b0), 1'b0, 32'h2000_0022},
        {mk(4'd1, 4'd0, 22'd0,  1'b0), 1'b0, 32'h2000_0011},
        {mk(4'd7, 4'd0, 22'd0,  1'b0), 1'b0, 32'h2000_0073},
        {mk(4'd4, 4'd0, 22'd0,  1'b0), 1'b0, 32'h2000_0040}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hst_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_wr_en = 1'b1;
        hst_waddr = a;
        hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [31:0] d);
        hst_raddr = a;
        #1;
        d = hst_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            host_rd(5'd17, v);
            if (!v[0]) return;
            @(negedge clk);
        end
        check("R3 request bit never cleared", v, 32'h0);
    endtask

    task automatic run(input logic [31:0] c);
        host_wr(5'd17, c);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p0;

        // table walk
        do_reset();
        for (int t = 0; t < 8; t++) begin
            auth_pass_i = VEC[t][32];
            run(VEC[t][64:33]);
            host_rd(5'd18, v);
            check($sformatf("R3 R7 R8 R10 vector %0d", t), v, VEC[t][31:0]);
        end
        check("R9 pulse count after table", 32'(pcount), 32'd1);

        // R13 reset state
        do_reset();
        host_rd(5'd17, v); check("R13 cmd after reset", v, 32'h0);
        host_rd(5'd18, v); check("R13 status after reset", v, 32'h0);
        host_rd(5'd1, v);  check("R13 window after reset", v, 32'h0);

        // R1 register map
        for (int i = 1; i <= 16; i++) host_wr(5'(i), 32'hA000_0000 + 32'(i));
        for (int i = 1; i <= 16; i++) begin
            host_rd(5'(i), v);
            check("R1 window readback", v, 32'hA000_0000 + 32'(i));
        end
        host_rd(5'd0, v);  check("R1 offset 0 reads zero", v, 32'h0);
        host_rd(5'd19, v); check("R1 offset 19 reads zero", v, 32'h0);
        host_wr(5'd18, 32'hFFFF_FFFF);
        host_rd(5'd18, v); check("R1 status is read-only", v, 32'h0);

        // R5 write lands in inactive bank
        run(mk(4'd0, 4'd15, 22'd4, 1'b0));
        host_rd(5'd18, v); check("R5 write status", v, 32'h2000_0000);
        run(mk(4'd2, 4'd0, 22'd4, 1'b0));
        host_rd(5'd1, v);  check("R5 active bank unchanged w0", v, 32'h0);
        host_rd(5'd16, v); check("R5 active bank unchanged w15", v, 32'h0);

        // R8 pass swaps, R4 full read
        auth_pass_i = 1'b1;
        run(mk(4'd1, 4'd0, 22'd0, 1'b0));
        host_rd(5'd18, v); check("R8 auth pass status", v, 32'h2000_0010);
        run(mk(4'd2, 4'd0, 22'd4, 1'b0));
        for (int i = 1; i <= 16; i++) begin
            host_rd(5'(i), v);
            check("R4 R8 full read after swap", v, 32'hA000_0000 + 32'(i));
        end

        // R2 R4 partial read
        for (int i = 1; i <= 16; i++) host_wr(5'(i), 32'hFFFF_FFFF);
        run(mk(4'd2, 4'd3, 22'd5, 1'b0));
        host_rd(5'd1, v); check("R2 R4 partial w0", v, 32'hA000_0002);
        host_rd(5'd3, v); check("R4 partial w2", v, 32'hA000_0004);
        host_rd(5'd4, v); check("R4 word past count kept", v, 32'hFFFF_FFFF);

        // R6 header region
        host_wr(5'd1, 32'h5A5A_0001);
        host_wr(5'd2, 32'h5A5A_0002);
        run(mk(4'd0, 4'd1, 22'd14, 1'b1));
        host_rd(5'd18, v); check("R6 header write status", v, 32'h2000_0000);
        host_wr(5'd1, 32'h0);
        host_wr(5'd2, 32'h0);
        run(mk(4'd2, 4'd2, 22'd14, 1'b1));
        host_rd(5'd1, v); check("R6 header read w0", v, 32'h5A5A_0001);
        host_rd(5'd2, v); check("R6 header read w1", v, 32'h5A5A_0002);
        run(mk(4'd2, 4'd1, 22'd14, 1'b0));
        host_rd(5'd1, v); check("R6 bank untouched by header write", v, 32'hA000_000B);

        // R7 bounds
        run(mk(4'd0, 4'd1, 22'd15, 1'b1));
        host_rd(5'd18, v); check("R7 header overrun", v, 32'h2000_0002);
        run(mk(4'd0, 4'd3, 22'd28, 1'b0));
        host_rd(5'd18, v); check("R7 exact end allowed", v, 32'h2000_0000);
        run(mk(4'd0, 4'd3, 22'd29, 1'b0));
        host_rd(5'd18, v); check("R7 one past end", v, 32'h2000_0002);
        host_wr(5'd1, 32'h7777_7777);
        run(mk(4'd2, 4'd2, 22'd31, 1'b0));
        host_rd(5'd18, v); check("R7 read overrun status", v, 32'h2000_0022);
        host_rd(5'd1, v);  check("R7 read overrun copies nothing", v, 32'h7777_7777);

        // R8 fail keeps banks
        auth_pass_i = 1'b0;
        run(mk(4'd1, 4'd0, 22'd0, 1'b0));
        host_rd(5'd18, v); check("R8 auth fail status", v, 32'h2000_0011);
        run(mk(4'd2, 4'd1, 22'd4, 1'b0));
        host_rd(5'd1, v);  check("R8 no swap on fail", v, 32'hA000_0001);

        // R10 unknown opcode
        host_wr(5'd1, 32'h0000_1234);
        run(mk(4'd9, 4'd0, 22'd4, 1'b0));
        host_rd(5'd18, v); check("R10 unknown status", v, 32'h2000_0093);
        host_rd(5'd1, v);  check("R10 window untouched", v, 32'h0000_1234);
        run(mk(4'd2, 4'd1, 22'd4, 1'b0));
        host_rd(5'd1, v);  check("R10 memory untouched", v, 32'hA000_0001);

        // R9 power cycle
        p0 = pcount;
        run(mk(4'd4, 4'd0, 22'd0, 1'b0));
        host_rd(5'd18, v); check("R9 power status", v, 32'h2000_0040);
        check("R9 one pulse", 32'(pcount - p0), 32'd1);

        // R11 command writes hammered until the request bit clears
        p0 = pcount;
        host_wr(5'd17, mk(4'd0, 4'd15, 22'd0, 1'b0));
        for (int i = 0; i < 400; i++) begin
            host_rd(5'd17, v);
            if (!v[0]) break;
            hst_wr_en = 1'b1;
            hst_waddr = 5'd17;
            hst_wdata = mk(4'd4, 4'd0, 22'd0, 1'b0);
            @(negedge clk);
            hst_wr_en = 1'b0;
        end
        host_rd(5'd18, v); check("R11 status names first command", v, 32'h2000_0000);
        host_rd(5'd17, v); check("R11 command register kept", {28'd0, v[31:28]}, 32'h0);
        check("R11 no pulse from ignored writes", 32'(pcount - p0), 32'd0);

        // R12 window write while busy
        host_wr(5'd5, 32'h0000_5555);
        host_wr(5'd17, mk(4'd1, 4'd0, 22'd0, 1'b0));
        host_wr(5'd5, 32'h0000_BEEF);
        wait_idle();
        host_rd(5'd5, v); check("R12 busy window write ignored", v, 32'h0000_5555);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule